// File: doc/BRIEF.md
# DMA Destination Address and Transfer Count Registers

This block keeps, for each channel of a multi-channel DMA controller, a 32-bit destination address and a transfer count. A CPU-side register bus reads and writes either register with a 32-bit or a 16-bit access. The transfer engine, which lives outside this block, pulses a per-channel beat-done strobe and supplies a size code for each completed beat. On each beat the destination address steps forward by the beat size and the count goes down by one.

When the last transfer completes, the block raises a one-cycle terminal-count pulse. The live address and the remaining count of every channel are always visible on output buses. A channel can hold its address fixed, which suits FIFO-like targets. A channel whose destination is selected by the acknowledge strobe in single-address mode keeps its address register untouched, and the block marks that address as not to be driven.

The bus address is laid out as follows. Bit 0 selects the half for 16-bit accesses (0 = bits 15:0, 1 = bits 31:16). Bit 1 selects the register (0 = destination address, 1 = count). The bits above bit 1 give the channel index. A 16-bit write takes its data from `bus_wdata_i[15:0]`. A read always returns the whole 32-bit register.

Top module: `dma_dst_regs`

## Requirements
- R1: After reset every terminal-count output is low, and it stays low while no beat arrives.
- R2: A 32-bit write (bus_half_i=0, address bit 1 = 0) replaces the selected channel's destination address. A read returns it, and dest_addr_o shows it.
- R3: A 16-bit write (bus_half_i=1) changes only the half chosen by address bit 0, and the other 16 bits keep their value. This holds for both registers.
- R4: The count register holds CNT_W bits. Reads return 0 in bits 31 down to CNT_W, and writes to those bits have no effect.
- R5: On a beat, the address advances by 1, 2 or 4 for size codes 0, 1 or 2. Code 3 advances it by 4.
- R6: While fixed_addr_i of a channel is high, its beats leave the address unchanged.
- R7: While ack_dest_i of a channel is high, its beats leave the address unchanged and dest_addr_en_o of that channel is low. Otherwise dest_addr_en_o is high.
- R8: Each beat lowers the count by one, modulo 2^CNT_W, so a count of 0 becomes all ones. xfer_cnt_o shows the remaining count.
- R9: tc_o of a channel is high for exactly the one cycle after the beat that moves its count from 1 to 0. It is low at all other times.
- R10: A channel started with a count of 0 performs exactly 2^CNT_W beats before its terminal-count pulse.
- R11: When a CPU write and a beat reach the same channel in one cycle, the written register takes the CPU value and ignores the beat, while the other register of that channel still follows the beat.
- R12: Channels are independent: a write or beat on one channel changes no other channel's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_half_i | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| bus_addr_i | input | BA_W | {channel, register select, half select} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| beat_done_i | input | NUM_CH | Per-channel completed-beat strobe |
| beat_size_i | input | 2*NUM_CH | Per-channel size code, 2 bits each |
| fixed_addr_i | input | NUM_CH | Per-channel hold-address control |
| ack_dest_i | input | NUM_CH | Per-channel acknowledge-addressed destination flag |
| dest_addr_o | output | 32*NUM_CH | Current destination address of each channel |
| xfer_cnt_o | output | CNT_W*NUM_CH | Remaining transfer count of each channel |
| tc_o | output | NUM_CH | Terminal-count pulse per channel |
| dest_addr_en_o | output | NUM_CH | Destination address is to be driven |

## Verification
The bench builds the block with four channels and CNT_W = 8. This keeps the structure of the full design but shrinks the zero-count case to 256 beats, so the complete wrap from 0 through all ones down to the terminal-count pulse fits in a short run. With an 8-bit count, the top 24 read bits are all hard zero, which tests the ignored-bits path harder than the default width does. A behavioural model of every channel is compared with all outputs on every cycle, including the same-cycle write-and-beat case.

// File: rtl/dma_dst_pkg.sv
package dma_dst_pkg;

    localparam int REG_W  = 32;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } beat_size_e;

    // Address increment for one beat of the given size code.
    function automatic logic [REG_W-1:0] step_of(input logic [1:0] sz);
        case (beat_size_e'(sz))
            SZ_BYTE: return REG_W'(1);
            SZ_HALF: return REG_W'(2);
            default: return REG_W'(4);
        endcase
    endfunction

    // Merge bus write data into a register for a 32-bit or 16-bit access.
    function automatic logic [REG_W-1:0] merge_write(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] wdata,
        input logic             half,
        input logic             hi
    );
        if (!half)
            return wdata;
        if (hi)
            return {wdata[HALF_W-1:0], old_v[HALF_W-1:0]};
        return {old_v[REG_W-1:HALF_W], wdata[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/dma_dst_decode.sv
module dma_dst_decode #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int BA_W   = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [BA_W-1:0]   bus_addr_i,
    output logic [NUM_CH-1:0] wr_addr_o,
    output logic [NUM_CH-1:0] wr_cnt_o,
    output logic [CH_W-1:0]   rd_ch_o,
    output logic              rd_cnt_sel_o,
    output logic              hi_o
);

    logic [CH_W-1:0] ch_sel;
    logic            cnt_sel;

    assign ch_sel       = bus_addr_i[BA_W-1:2];
    assign cnt_sel      = bus_addr_i[1];
    assign hi_o         = bus_addr_i[0];
    assign rd_ch_o      = ch_sel;
    assign rd_cnt_sel_o = cnt_sel;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        logic hit;
        assign hit          = bus_wr_i && (ch_sel == CH_W'(g));
        assign wr_addr_o[g] = hit && !cnt_sel;
        assign wr_cnt_o[g]  = hit && cnt_sel;
    end

    // R12: at most one register of one channel is written per cycle
    assert_one_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_addr_o, wr_cnt_o}));

endmodule

// File: rtl/dma_dst_chan.sv
module dma_dst_chan
    import dma_dst_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_addr_i,
    input  logic             wr_cnt_i,
    input  logic             half_i,
    input  logic             hi_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             beat_i,
    input  logic [1:0]       size_i,
    input  logic             fixed_i,
    input  logic             ack_dest_i,
    output logic [REG_W-1:0] addr_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tc_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [CNT_W-1:0] cnt;
        logic             tc;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [REG_W-1:0] cnt_wide;
    logic             addr_moves;

    always_comb begin
        st_d       = st_q;
        st_d.tc    = 1'b0;
        cnt_wide   = '0;
        cnt_wide[CNT_W-1:0] = st_q.cnt;
        addr_moves = beat_i && !fixed_i && !ack_dest_i;

        if (wr_addr_i)
            st_d.addr = merge_write(st_q.addr, wdata_i, half_i, hi_i);
        else if (addr_moves)
            st_d.addr = st_q.addr + step_of(size_i);

        if (wr_cnt_i) begin
            st_d.cnt = CNT_W'(merge_write(cnt_wide, wdata_i, half_i, hi_i));
        end else if (beat_i) begin
            st_d.cnt = st_q.cnt - CNT_ONE;
            st_d.tc  = (st_q.cnt == CNT_ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign cnt_o  = st_q.cnt;
    assign tc_o   = st_q.tc;

    // R6: a fixed-address channel keeps its address across a beat
    assert_fixed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_i && fixed_i && !wr_addr_i |=> $stable(addr_o));

    // R7: an acknowledge-addressed destination keeps the register untouched
    assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_i && ack_dest_i && !wr_addr_i |=> $stable(addr_o));

    // R8: each uncontested beat lowers the count by exactly one
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_i && !wr_cnt_i |=> cnt_o == $past(cnt_o) - CNT_ONE);

    // R8: without beat or write the count is steady
    assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_i && !wr_cnt_i |=> $stable(cnt_o));

    // R9: a terminal-count pulse always leaves the count at zero
    assert_tc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> cnt_o == '0);

    // R9: terminal count lasts a single cycle
    assert_tc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> !tc_o);

    // R11: a CPU count write in the same cycle suppresses terminal count
    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> !tc_o);

endmodule

// File: rtl/dma_dst_regs.sv
module dma_dst_regs
    import dma_dst_pkg::*;
#(
    parameter  int NUM_CH = 4,
    parameter  int CNT_W  = 24,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BA_W   = CH_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr_i,
    input  logic                    bus_half_i,
    input  logic [BA_W-1:0]         bus_addr_i,
    input  logic [31:0]             bus_wdata_i,
    output logic [31:0]             bus_rdata_o,
    input  logic [NUM_CH-1:0]       beat_done_i,
    input  logic [2*NUM_CH-1:0]     beat_size_i,
    input  logic [NUM_CH-1:0]       fixed_addr_i,
    input  logic [NUM_CH-1:0]       ack_dest_i,
    output logic [32*NUM_CH-1:0]    dest_addr_o,
    output logic [CNT_W*NUM_CH-1:0] xfer_cnt_o,
    output logic [NUM_CH-1:0]       tc_o,
    output logic [NUM_CH-1:0]       dest_addr_en_o
);

    logic [NUM_CH-1:0] wr_addr;
    logic [NUM_CH-1:0] wr_cnt;
    logic [CH_W-1:0]   rd_ch;
    logic              rd_cnt_sel;
    logic              half_hi;

    logic [REG_W-1:0]  addr_arr [NUM_CH];
    logic [CNT_W-1:0]  cnt_arr  [NUM_CH];

    dma_dst_decode #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .BA_W   (BA_W)
    ) i_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr_i     (bus_wr_i),
        .bus_addr_i   (bus_addr_i),
        .wr_addr_o    (wr_addr),
        .wr_cnt_o     (wr_cnt),
        .rd_ch_o      (rd_ch),
        .rd_cnt_sel_o (rd_cnt_sel),
        .hi_o         (half_hi)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_dst_chan #(
            .CNT_W (CNT_W)
        ) i_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_addr_i  (wr_addr[g]),
            .wr_cnt_i   (wr_cnt[g]),
            .half_i     (bus_half_i),
            .hi_i       (half_hi),
            .wdata_i    (bus_wdata_i),
            .beat_i     (beat_done_i[g]),
            .size_i     (beat_size_i[2*g +: 2]),
            .fixed_i    (fixed_addr_i[g]),
            .ack_dest_i (ack_dest_i[g]),
            .addr_o     (addr_arr[g]),
            .cnt_o      (cnt_arr[g]),
            .tc_o       (tc_o[g])
        );

        assign dest_addr_o[32*g +: 32]      = addr_arr[g];
        assign xfer_cnt_o[CNT_W*g +: CNT_W] = cnt_arr[g];
        assign dest_addr_en_o[g]            = !ack_dest_i[g];
    end

    // Read mux: counts are zero-extended to the full register width.
    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == CH_W'(i))
                bus_rdata_o = rd_cnt_sel ? REG_W'(cnt_arr[i]) : addr_arr[i];
        end
    end

    if (CNT_W < 32) begin : g_cnt_pad_chk
        // R4: bits above the count width always read back as zero
        assert_cnt_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_cnt_sel |-> bus_rdata_o[31:CNT_W] == '0);
    end

endmodule

// File: tb/test_dma_dst_regs.sv
module test_dma_dst_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int CW         = 8;
    localparam int BAW        = 4;
    localparam logic [31:0] CMASK = (32'd1 << CW) - 32'd1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_wr = 1'b0;
    logic                 bus_half = 1'b0;
    logic [BAW-1:0]       bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NCH-1:0]       beat = '0;
    logic [2*NCH-1:0]     bsize = '0;
    logic [NCH-1:0]       fixed = '0;
    logic [NCH-1:0]       ack = '0;
    logic [32*NCH-1:0]    dest_addr;
    logic [CW*NCH-1:0]    xfer_cnt;
    logic [NCH-1:0]       tc;
    logic [NCH-1:0]       addr_en;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit cmp_regs = 1'b0;
    int tc_seen = 0;

    logic [31:0] m_addr [NCH];
    logic [31:0] m_cnt  [NCH];
    logic        m_tc   [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_dst_regs #(.NUM_CH(NCH), .CNT_W(CW)) i_dma_dst_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wr_i       (bus_wr),
        .bus_half_i     (bus_half),
        .bus_addr_i     (bus_addr),
        .bus_wdata_i    (bus_wdata),
        .bus_rdata_o    (bus_rdata),
        .beat_done_i    (beat),
        .beat_size_i    (bsize),
        .fixed_addr_i   (fixed),
        .ack_dest_i     (ack),
        .dest_addr_o    (dest_addr),
        .xfer_cnt_o     (xfer_cnt),
        .tc_o           (tc),
        .dest_addr_en_o (addr_en)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] w,
                                          input logic h, input logic hi);
        if (!h) return w;
        return hi ? {w[15:0], o[15:0]} : {o[31:16], w[15:0]};
    endfunction

    // Reference model: one clock of behaviour from the requirements.
    task automatic model_step();
        for (int c = 0; c < NCH; c++) begin
            bit wa, wc;
            int sz;
            wa = bus_wr && (int'(bus_addr[3:2]) == c) && !bus_addr[1];
            wc = bus_wr && (int'(bus_addr[3:2]) == c) && bus_addr[1];
            sz = int'(bsize[2*c +: 2]);
            m_tc[c] = 1'b0;
            if (wa)
                m_addr[c] = merge(m_addr[c], bus_wdata, bus_half, bus_addr[0]);
            else if (beat[c] && !fixed[c] && !ack[c])
                m_addr[c] = m_addr[c] + ((sz == 0) ? 32'd1 : (sz == 1) ? 32'd2 : 32'd4);
            if (wc) begin
                m_cnt[c] = merge(m_cnt[c], bus_wdata, bus_half, bus_addr[0]) & CMASK;
            end else if (beat[c]) begin
                m_tc[c]  = (m_cnt[c] == 32'd1);
                m_cnt[c] = (m_cnt[c] - 32'd1) & CMASK;
            end
        end
    endtask

    task automatic compare_all();
        for (int c = 0; c < NCH; c++) begin
            chk(cur_req, $sformatf("tc ch%0d", c), 32'(tc[c]), 32'(m_tc[c]));
            chk("R7", $sformatf("addr_en ch%0d", c), 32'(addr_en[c]), 32'(!ack[c]));
            if (tc[c]) tc_seen++;
            if (cmp_regs) begin
                chk(cur_req, $sformatf("addr ch%0d", c), dest_addr[32*c +: 32], m_addr[c]);
                chk(cur_req, $sformatf("cnt ch%0d", c), 32'(xfer_cnt[CW*c +: CW]), m_cnt[c]);
            end
        end
        if (cmp_regs) begin
            int rc;
            rc = int'(bus_addr[3:2]);
            chk(cur_req, "rdata", bus_rdata, bus_addr[1] ? m_cnt[rc] : m_addr[rc]);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        bus_wr = 1'b0;
        beat   = '0;
    endtask

    task automatic cpu_wr(input int c, input bit cnt_reg, input bit half,
                          input bit hi, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_half  = half;
        bus_addr  = {2'(c), cnt_reg, hi};
        bus_wdata = d;
        tick();
    endtask

    task automatic rd(input int c, input bit cnt_reg);
        bus_addr = {2'(c), cnt_reg, 1'b0};
        tick();
    endtask

    task automatic do_beat(input int c, input int sz);
        beat[c] = 1'b1;
        bsize[2*c +: 2] = 2'(sz);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_addr[c] = '0; m_cnt[c] = '0; m_tc[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: terminal count low out of reset and while idle
        cur_req = "R1";
        for (int i = 0; i < 3; i++) tick();

        // R2: full writes load every register; readback
        cur_req = "R2";
        for (int c = 0; c < NCH; c++) begin
            m_addr[c] = 32'hx; m_cnt[c] = 32'hx;
            cpu_wr(c, 1'b0, 1'b0, 1'b0, 32'h8000_0000 + 32'(c) * 32'h0001_0100);
            cpu_wr(c, 1'b1, 1'b0, 1'b0, 32'(c + 3));
        end
        cmp_regs = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            rd(c, 1'b0);
            rd(c, 1'b1);
        end

        // R3: half writes keep the other half
        cur_req = "R3";
        cpu_wr(1, 1'b0, 1'b1, 1'b0, 32'hFFFF_BEEF);
        rd(1, 1'b0);
        cpu_wr(1, 1'b0, 1'b1, 1'b1, 32'h0000_CAFE);
        rd(1, 1'b0);
        chk("R3", "half merged addr", dest_addr[63:32], 32'hCAFE_BEEF);
        cpu_wr(0, 1'b1, 1'b1, 1'b0, 32'h0000_0042);
        rd(0, 1'b1);

        // R4: upper count bits ignored and read as zero
        cur_req = "R4";
        cpu_wr(3, 1'b1, 1'b0, 1'b0, 32'hABCD_1234);
        rd(3, 1'b1);
        chk("R4", "count readback", bus_rdata, 32'h0000_0034);
        cpu_wr(3, 1'b1, 1'b1, 1'b1, 32'h0000_FFFF);
        rd(3, 1'b1);
        chk("R4", "high half write no effect", bus_rdata, 32'h0000_0034);

        // R5: step sizes 1, 2, 4 and reserved code
        cur_req = "R5";
        cpu_wr(0, 1'b0, 1'b0, 1'b0, 32'h0000_1000);
        cpu_wr(0, 1'b1, 1'b0, 1'b0, 32'h0000_0050);
        for (int s = 0; s < 4; s++) do_beat(0, s);
        chk("R5", "addr after 1+2+4+4", dest_addr[31:0], 32'h0000_100B);

        // R6: fixed address
        cur_req = "R6";
        fixed[1] = 1'b1;
        for (int i = 0; i < 3; i++) do_beat(1, 2);
        fixed[1] = 1'b0;
        chk("R6", "fixed addr held", dest_addr[63:32], 32'hCAFE_BEEF);

        // R7: acknowledge-addressed destination
        cur_req = "R7";
        ack[2] = 1'b1;
        do_beat(2, 1);
        do_beat(2, 2);
        ack[2] = 1'b0;
        tick();

        // R8: decrement and wrap from zero
        cur_req = "R8";
        cpu_wr(3, 1'b1, 1'b0, 1'b0, 32'd0);
        do_beat(3, 0);
        chk("R8", "wrap to all ones", 32'(xfer_cnt[CW*3 +: CW]), CMASK);
        do_beat(3, 0);

        // R9: terminal count on 1 -> 0
        cur_req = "R9";
        cpu_wr(0, 1'b1, 1'b0, 1'b0, 32'd2);
        do_beat(0, 2);
        chk("R9", "no tc at 2->1", 32'(tc[0]), 32'd0);
        do_beat(0, 2);
        chk("R9", "tc at 1->0", 32'(tc[0]), 32'd1);
        tick();
        chk("R9", "tc single cycle", 32'(tc[0]), 32'd0);

        // R10: zero count runs 2^CW beats
        cur_req = "R10";
        cpu_wr(2, 1'b1, 1'b0, 1'b0, 32'd0);
        tc_seen = 0;
        for (int i = 0; i < (1 << CW) - 1; i++) do_beat(2, 0);
        chk("R10", "no tc before last beat", 32'(tc_seen), 32'd0);
        do_beat(2, 0);
        chk("R10", "tc after 2^CW beats", 32'(tc_seen), 32'd1);

        // R11: same-cycle write wins over beat
        cur_req = "R11";
        cpu_wr(1, 1'b1, 1'b0, 1'b0, 32'd1);
        beat[1] = 1'b1; bsize[3:2] = 2'd2;
        cpu_wr(1, 1'b1, 1'b0, 1'b0, 32'd1);
        chk("R11", "count takes write", 32'(xfer_cnt[CW*1 +: CW]), 32'd1);
        chk("R11", "no tc on write", 32'(tc[1]), 32'd0);
        beat[1] = 1'b1; bsize[3:2] = 2'd2;
        cpu_wr(1, 1'b0, 1'b0, 1'b0, 32'h0000_2000);
        chk("R11", "addr takes write", dest_addr[63:32], 32'h0000_2000);

        // R12: independent channels, concurrent activity
        cur_req = "R12";
        cpu_wr(0, 1'b1, 1'b0, 1'b0, 32'd9);
        beat = 4'b1011; bsize = 8'b10_01_00_10;
        cpu_wr(2, 1'b0, 1'b0, 1'b0, 32'h0000_4000);
        beat = 4'b1111; bsize = 8'b00_01_10_11;
        tick();
        rd(2, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule